// File: doc/BRIEF.md
# Memory Region Security Checker

This block sits beside the bus fabric and judges every access aimed at flash or RAM. Both memories are split into equal power-of-two regions. Each region holds three permission bits (read, write, execute), a secure marker and a lock bit. Every access presents an address, a kind (read, write or instruction fetch) and a secure flag. The block answers allow or deny combinationally, in the same cycle.

A non-secure access to a secure region is refused. The one exception is an instruction fetch that lands in that memory's non-secure-callable window. This window is one entry per memory that names a region and a size. It covers the top bytes of the named region.

Software programs the table through a simple word-addressed register port. A lock bit freezes an entry until reset. Every refused access raises a sticky violation flag for its memory. Each flag has its own interrupt enable, and the interrupt line is raised while any enabled flag is pending.

Top module: `mem_sec_checker`

## Requirements
- R1: After reset, every region word reads 0x0F (read, write, execute and secure set, unlocked). Both window words, the violation flags and the enable mask read 0, and `irq` is low.
- R2: A region word has read at bit 0, write at bit 1, execute at bit 2, secure at bit 3 and lock at bit 4. The access kind is encoded as 0 = read, 1 = write, 2 = fetch. Each kind is allowed only if its bit is set. Kind 3 is always denied.
- R3: A secure access is judged on permissions alone. A non-secure access to a region whose secure bit is set is denied, except as stated in R4.
- R4: A window word holds a size code at bits [3:0] and a region number at bits [8 +: index width]. Codes 1 to 8 select 32 << (code-1) bytes; codes 0 and 9 to 15 disable the window. A non-secure fetch whose offset lies in the top that-many bytes of the named secure region is allowed if execute is set. Non-secure reads and writes in the window stay denied.
- R5: Address bit ADDR_W-1 selects the memory (0 flash, 1 RAM). The region index is the address bits starting at REGION_SHIFT, one bit per index bit. Bits above the index and below the memory bit are ignored.
- R6: Once a region word has its lock bit set, later writes to it are ignored and it reads back unchanged. A window word with bit 16 set behaves the same way.
- R7: A denied valid access sets violation flag bit 0 (flash) or bit 1 (RAM) at the next clock edge. The flag stays set until software writes 1 to that bit of the flag word. A violation in the same cycle as a clear leaves the flag set.
- R8: Writing 1s to the enable-set word sets enable bits, and writing 1s to the enable-clear word clears them. Both words read back the enable mask (bit 0 flash, bit 1 RAM).
- R9: `irq` is high exactly while some violation flag and its enable are both set.
- R10: `acc_allow` is low whenever `acc_valid` is low.

Register word map (cfg_addr, NREG = 8): 0..7 flash regions, 8..15 RAM regions, 16 flash window, 17 RAM window, 18 violation flags, 19 enable set, 20 enable clear. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Access byte address |
| acc_type | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| acc_secure | input | 1 | Access carries the secure attribute |
| acc_allow | output | 1 | Access permitted this cycle |
| irq | output | 1 | Enabled violation pending |

## Verification
Several properties are checked on every clock. An idle request is never allowed, and kind 3 is never allowed. Any allowed access has the matching permission bit set, and a non-secure data access is never allowed into a secure region. A refused access always leaves its memory's flag set one cycle later. A flag persists unless cleared, a locked region word never changes, and the interrupt implies a pending flag and an enable. The sized window boundaries, the handling of out-of-range size codes, the aliasing of upper address bits, and the ordering of a simultaneous violation and clear can only be shown by the bench's directed scenarios. The same holds for reset readback and window-word locking.

// File: rtl/mem_sec_pkg.sv
// Shared types and field positions for the memory region security checker.
// Assumes at most 256 regions per memory (window region field is 8 bits wide).
package mem_sec_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_BAD   = 2'd3
    } acc_kind_e;

    // Region word layout, LSB first: read, write, exec, secure, lock.
    typedef struct packed {
        logic lock;
        logic secure;
        logic exec;
        logic write;
        logic read;
    } region_cfg_t;

    localparam int REGION_CFG_W  = 5;
    localparam int NSC_CODE_LSB  = 0;
    localparam int NSC_REG_LSB   = 8;
    localparam int NSC_LOCK_BIT  = 16;
    localparam int NMEM          = 2;
    localparam int MEM_FLASH     = 0;
    localparam int MEM_RAM       = 1;

    // Window size in bytes for a 4-bit size code; 0 when disabled.
    function automatic logic [13:0] nsc_bytes(input logic [3:0] code);
        if (code == 4'd0 || code > 4'd8) begin
            return 14'd0;
        end
        return 14'd1 << (code + 4'd4);
    endfunction

endpackage

// File: rtl/msc_region_bank.sv
// Configuration storage for one memory: NREG region words and one
// non-secure-callable window word, each with a write-once lock.
// Assumes NREG is a power of two and at least 2.
module msc_region_bank
    import mem_sec_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int IDX_W    = 3,
    parameter int CFG_AW   = 5,
    parameter int REG_BASE = 0,
    parameter int NSC_ADDR = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [31:0]                  cfg_wdata,
    output region_cfg_t [NREG-1:0]       region_o,
    output logic [3:0]                   nsc_code_o,
    output logic [IDX_W-1:0]             nsc_region_o,
    output logic [31:0]                  rdata_o
);

    localparam region_cfg_t REGION_RESET = '{lock: 1'b0, secure: 1'b1,
                                             exec: 1'b1, write: 1'b1, read: 1'b1};

    region_cfg_t [NREG-1:0] region_q;
    logic [3:0]             nsc_code_q;
    logic [IDX_W-1:0]       nsc_region_q;
    logic                   nsc_lock_q;
    logic                   unused_wdata;

    assign unused_wdata = ^cfg_wdata;

    // Region words: load on an addressed write unless locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                region_q[i] <= REGION_RESET;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (cfg_we && cfg_addr == CFG_AW'(REG_BASE + i) && !region_q[i].lock) begin
                    region_q[i] <= region_cfg_t'(cfg_wdata[REGION_CFG_W-1:0]);
                end
            end
        end
    end

    // Window word: load on an addressed write unless locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nsc_code_q   <= '0;
            nsc_region_q <= '0;
            nsc_lock_q   <= 1'b0;
        end else if (cfg_we && cfg_addr == CFG_AW'(NSC_ADDR) && !nsc_lock_q) begin
            nsc_code_q   <= cfg_wdata[NSC_CODE_LSB +: 4];
            nsc_region_q <= cfg_wdata[NSC_REG_LSB +: IDX_W];
            nsc_lock_q   <= cfg_wdata[NSC_LOCK_BIT];
        end
    end

    // Read mux for the words this bank owns; zero elsewhere.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (cfg_addr == CFG_AW'(REG_BASE + i)) begin
                rdata_o = 32'(region_q[i]);
            end
        end
        if (cfg_addr == CFG_AW'(NSC_ADDR)) begin
            rdata_o[NSC_CODE_LSB +: 4]     = nsc_code_q;
            rdata_o[NSC_REG_LSB +: IDX_W]  = nsc_region_q;
            rdata_o[NSC_LOCK_BIT]          = nsc_lock_q;
        end
    end

    assign region_o     = region_q;
    assign nsc_code_o   = nsc_code_q;
    assign nsc_region_o = nsc_region_q;

endmodule

// File: rtl/msc_access_judge.sv
// Combinational allow/deny decision for one memory: permission check by
// access kind, secure-attribute check and non-secure-callable window test.
// Assumes the window lies at the top of its region (offset + size >= region size).
module msc_access_judge
    import mem_sec_pkg::*;
#(
    parameter int NREG         = 8,
    parameter int IDX_W        = 3,
    parameter int REGION_SHIFT = 12
) (
    input  region_cfg_t [NREG-1:0]  region_i,
    input  logic [3:0]              nsc_code_i,
    input  logic [IDX_W-1:0]        nsc_region_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [REGION_SHIFT-1:0] offset_i,
    input  logic [1:0]              kind_i,
    input  logic                    secure_i,
    output logic                    allow_o
);

    localparam int SUM_W = ((REGION_SHIFT > 13) ? REGION_SHIFT : 13) + 1;
    localparam logic [SUM_W-1:0] REGION_BYTES = SUM_W'(1) << REGION_SHIFT;

    region_cfg_t  cur;
    logic         perm_ok;
    logic         in_window;
    logic         sec_ok;
    logic [13:0]  win_bytes;
    logic         unused_lock;

    assign cur         = region_i[idx_i];
    assign unused_lock = cur.lock;

    // Permission bit selected by the access kind.
    always_comb begin
        case (kind_i)
            ACC_READ:  perm_ok = cur.read;
            ACC_WRITE: perm_ok = cur.write;
            ACC_FETCH: perm_ok = cur.exec;
            default:   perm_ok = 1'b0;
        endcase
    end

    // Window hit: named region, enabled size, offset in the top bytes.
    always_comb begin
        win_bytes = nsc_bytes(nsc_code_i);
        in_window = (win_bytes != 14'd0) && (idx_i == nsc_region_i) &&
                    ((SUM_W'(offset_i) + SUM_W'(win_bytes)) >= REGION_BYTES);
    end

    // Security: secure masters pass; non-secure needs an open region or a window fetch.
    always_comb begin
        sec_ok  = secure_i || !cur.secure || (kind_i == ACC_FETCH && in_window);
        allow_o = perm_ok && sec_ok;
    end

endmodule

// File: rtl/msc_event_unit.sv
// Sticky violation flags with write-1-to-clear, set/clear interrupt enables
// and the interrupt line. A violation in the same cycle as a clear wins.
module msc_event_unit #(
    parameter int NEVT         = 2,
    parameter int CFG_AW       = 5,
    parameter int EVT_ADDR     = 18,
    parameter int IEN_SET_ADDR = 19,
    parameter int IEN_CLR_ADDR = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [NEVT-1:0]   viol_i,
    output logic [NEVT-1:0]   evt_o,
    output logic [NEVT-1:0]   ien_o,
    output logic              irq_o,
    output logic [31:0]       rdata_o
);

    logic [NEVT-1:0] evt_q;
    logic [NEVT-1:0] ien_q;
    logic [NEVT-1:0] clr_mask;
    logic            unused_wdata;

    assign unused_wdata = ^cfg_wdata;
    assign clr_mask = (cfg_we && cfg_addr == CFG_AW'(EVT_ADDR)) ? cfg_wdata[NEVT-1:0] : '0;

    // Flags: clear requested bits, then OR in this cycle's violations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= (evt_q & ~clr_mask) | viol_i;
        end
    end

    // Enables: separate set and clear words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (cfg_we && cfg_addr == CFG_AW'(IEN_SET_ADDR)) begin
            ien_q <= ien_q | cfg_wdata[NEVT-1:0];
        end else if (cfg_we && cfg_addr == CFG_AW'(IEN_CLR_ADDR)) begin
            ien_q <= ien_q & ~cfg_wdata[NEVT-1:0];
        end
    end

    // Read mux for flag and enable words.
    always_comb begin
        rdata_o = '0;
        if (cfg_addr == CFG_AW'(EVT_ADDR)) begin
            rdata_o[NEVT-1:0] = evt_q;
        end else if (cfg_addr == CFG_AW'(IEN_SET_ADDR) || cfg_addr == CFG_AW'(IEN_CLR_ADDR)) begin
            rdata_o[NEVT-1:0] = ien_q;
        end
    end

    assign evt_o = evt_q;
    assign ien_o = ien_q;
    assign irq_o = |(evt_q & ien_q);

endmodule

// File: rtl/mem_sec_checker.sv
// Top of the memory region security checker. Decodes the memory and region
// from the access address, runs one bank and one judge per memory, and
// routes denials to the violation flags.
// Assumes ADDR_W > REGION_SHIFT + log2(NREG) and NREG a power of two >= 2.
module mem_sec_checker
    import mem_sec_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int REGION_SHIFT = 12,
    parameter int NREG         = 8,
    localparam int IDX_W       = $clog2(NREG),
    localparam int CFG_WORDS   = 2 * NREG + 5,
    localparam int CFG_AW      = $clog2(CFG_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_type,
    input  logic              acc_secure,
    output logic              acc_allow,
    output logic              irq
);

    localparam int NSC_BASE     = 2 * NREG;
    localparam int EVT_ADDR     = 2 * NREG + 2;
    localparam int IEN_SET_ADDR = 2 * NREG + 3;
    localparam int IEN_CLR_ADDR = 2 * NREG + 4;

    region_cfg_t [NREG-1:0]  region_w [NMEM];
    logic [3:0]              nsc_code_w [NMEM];
    logic [IDX_W-1:0]        nsc_region_w [NMEM];
    logic [31:0]             bank_rdata_w [NMEM];
    logic [NMEM-1:0]         allow_w;
    logic [31:0]             evt_rdata;
    logic [NMEM-1:0]         evt_w;
    logic [NMEM-1:0]         ien_w;
    logic [NMEM-1:0]         viol;
    logic [2*NREG*REGION_CFG_W-1:0] region_flat;
    logic                    mem_sel;
    logic [IDX_W-1:0]        idx;
    logic [REGION_SHIFT-1:0] offset;
    logic                    allow_sel;
    logic                    unused_addr;

    assign mem_sel     = acc_addr[ADDR_W-1];
    assign idx         = acc_addr[REGION_SHIFT +: IDX_W];
    assign offset      = acc_addr[REGION_SHIFT-1:0];
    assign unused_addr = ^acc_addr;

    // One configuration bank and one decision unit per memory.
    for (genvar m = 0; m < NMEM; m++) begin : g_mem
        msc_region_bank #(
            .NREG(NREG), .IDX_W(IDX_W), .CFG_AW(CFG_AW),
            .REG_BASE(m * NREG), .NSC_ADDR(NSC_BASE + m)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
            .cfg_wdata(cfg_wdata), .region_o(region_w[m]),
            .nsc_code_o(nsc_code_w[m]), .nsc_region_o(nsc_region_w[m]),
            .rdata_o(bank_rdata_w[m])
        );

        msc_access_judge #(
            .NREG(NREG), .IDX_W(IDX_W), .REGION_SHIFT(REGION_SHIFT)
        ) u_judge (
            .region_i(region_w[m]), .nsc_code_i(nsc_code_w[m]),
            .nsc_region_i(nsc_region_w[m]), .idx_i(idx), .offset_i(offset),
            .kind_i(acc_type), .secure_i(acc_secure), .allow_o(allow_w[m])
        );

        for (genvar g = 0; g < NREG; g++) begin : g_flat
            assign region_flat[(m*NREG+g)*REGION_CFG_W +: REGION_CFG_W] = region_w[m][g];
        end
    end

    // Select the addressed memory's verdict and flag its denials.
    always_comb begin
        allow_sel          = allow_w[mem_sel];
        acc_allow          = acc_valid && allow_sel;
        viol               = '0;
        viol[MEM_FLASH]    = acc_valid && !allow_sel && !mem_sel;
        viol[MEM_RAM]      = acc_valid && !allow_sel && mem_sel;
    end

    msc_event_unit #(
        .NEVT(NMEM), .CFG_AW(CFG_AW), .EVT_ADDR(EVT_ADDR),
        .IEN_SET_ADDR(IEN_SET_ADDR), .IEN_CLR_ADDR(IEN_CLR_ADDR)
    ) u_evt (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .viol_i(viol), .evt_o(evt_w), .ien_o(ien_w),
        .irq_o(irq), .rdata_o(evt_rdata)
    );

    // Merge read data; each source drives zero outside its own words.
    assign cfg_rdata = bank_rdata_w[MEM_FLASH] | bank_rdata_w[MEM_RAM] | evt_rdata;

endmodule

// File: rtl/mem_sec_checker_chk.sv
// Property checker for mem_sec_checker, attached by bind below.
module mem_sec_checker_chk
    import mem_sec_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int REGION_SHIFT = 12,
    parameter int NREG         = 8,
    parameter int CFG_AW       = 5,
    parameter int EVT_ADDR     = 18
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            cfg_we,
    input logic [CFG_AW-1:0]               cfg_addr,
    input logic [31:0]                     cfg_wdata,
    input logic                            acc_valid,
    input logic [ADDR_W-1:0]               acc_addr,
    input logic [1:0]                      acc_type,
    input logic                            acc_secure,
    input logic                            acc_allow,
    input logic                            irq,
    input logic [NMEM-1:0]                 evt,
    input logic [NMEM-1:0]                 ien,
    input logic [2*NREG*REGION_CFG_W-1:0]  region_flat
);

    localparam int IDX_W = $clog2(NREG);

    logic [REGION_CFG_W-1:0] hit_word;
    logic                    unused_chk;
    logic                    evt_clr0;
    logic                    evt_clr1;

    assign hit_word = region_flat[(int'(acc_addr[ADDR_W-1]) * NREG +
                                   int'(acc_addr[REGION_SHIFT +: IDX_W])) * REGION_CFG_W +: REGION_CFG_W];
    assign evt_clr0   = cfg_we && cfg_addr == CFG_AW'(EVT_ADDR) && cfg_wdata[0];
    assign evt_clr1   = cfg_we && cfg_addr == CFG_AW'(EVT_ADDR) && cfg_wdata[1];
    assign unused_chk = ^{acc_addr, cfg_wdata};

    assert_idle_no_allow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_allow);

    assert_bad_kind_denied_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_type == 2'd3) |-> !acc_allow);

    assert_perm_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_allow |-> ((acc_type == 2'd0 && hit_word[0]) ||
                       (acc_type == 2'd1 && hit_word[1]) ||
                       (acc_type == 2'd2 && hit_word[2])));

    assert_ns_data_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_allow && !acc_secure && acc_type != 2'd2) |-> !hit_word[3]);

    assert_flash_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_allow && !acc_addr[ADDR_W-1]) |=> evt[0]);

    assert_ram_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_allow && acc_addr[ADDR_W-1]) |=> evt[1]);

    assert_flash_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[0] && !evt_clr0) |=> evt[0]);

    assert_ram_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[1] && !evt_clr1) |=> evt[1]);

    assert_irq_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|ien));

    assert_irq_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|evt));

    for (genvar g = 0; g < 2 * NREG; g++) begin : g_lock
        assert_locked_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
            region_flat[g*REGION_CFG_W + 4] |=> $stable(region_flat[g*REGION_CFG_W +: REGION_CFG_W]));
    end

endmodule

bind mem_sec_checker mem_sec_checker_chk #(
    .ADDR_W(ADDR_W), .REGION_SHIFT(REGION_SHIFT), .NREG(NREG),
    .CFG_AW(CFG_AW), .EVT_ADDR(EVT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_type(acc_type), .acc_secure(acc_secure), .acc_allow(acc_allow),
    .irq(irq), .evt(evt_w), .ien(ien_w), .region_flat(region_flat)
);

// File: tb/mem_sec_checker_test.sv
module mem_sec_checker_test;

    localparam int PERIOD = 10;
    localparam int AW     = 20;

    typedef struct packed {
        logic [19:0] addr;
        logic [1:0]  kind;
        logic        sec;
        logic        exp;
        logic [15:0] req;
    } vec_t;

    // Table assumes: flash r1 = RW open, flash r2 = R+X secure with a
    // 128-byte window, RAM r3 = R open, RAM r5 = RW secure.
    localparam vec_t VECS [16] = '{
        '{20'h00010, 2'd0, 1'b1, 1'b1, "R5"},
        '{20'h00010, 2'd0, 1'b0, 1'b0, "R3"},
        '{20'h01000, 2'd1, 1'b0, 1'b1, "R3"},
        '{20'h01000, 2'd2, 1'b0, 1'b0, "R2"},
        '{20'h02F80, 2'd2, 1'b0, 1'b1, "R4"},
        '{20'h02F7F, 2'd2, 1'b0, 1'b0, "R4"},
        '{20'h02FFF, 2'd0, 1'b0, 1'b0, "R4"},
        '{20'h02000, 2'd2, 1'b1, 1'b1, "R3"},
        '{20'h02000, 2'd1, 1'b1, 1'b0, "R2"},
        '{20'h83004, 2'd0, 1'b0, 1'b1, "R5"},
        '{20'h83004, 2'd1, 1'b0, 1'b0, "R2"},
        '{20'h85000, 2'd1, 1'b1, 1'b1, "R3"},
        '{20'h85000, 2'd1, 1'b0, 1'b0, "R3"},
        '{20'h01000, 2'd3, 1'b1, 1'b0, "R2"},
        '{20'h03FFC, 2'd2, 1'b0, 1'b0, "R4"},
        '{20'h8B000, 2'd0, 1'b0, 1'b1, "R5"}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]  acc_type = '0;
    logic        acc_secure = 1'b0;
    logic        acc_allow;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    mem_sec_checker #(.ADDR_W(AW), .REGION_SHIFT(12), .NREG(8)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_type(acc_type), .acc_secure(acc_secure),
        .acc_allow(acc_allow), .irq(irq)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // One-cycle access; returns the same-cycle verdict.
    task automatic access(input logic [19:0] a, input logic [1:0] k,
                          input logic s, output logic allow);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_type = k; acc_secure = s;
        #1;
        allow = acc_allow;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        al;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cfg_read(5'd0, rd);  check("R1", "flash region 0", rd, 32'h0F);
        cfg_read(5'd8, rd);  check("R1", "ram region 0", rd, 32'h0F);
        cfg_read(5'd16, rd); check("R1", "flash window", rd, 32'h0);
        cfg_read(5'd18, rd); check("R1", "flags", rd, 32'h0);
        cfg_read(5'd19, rd); check("R1", "enables", rd, 32'h0);
        check("R1", "irq", 32'(irq), 32'h0);

        // R10: idle request never allowed
        @(negedge clk);
        acc_addr = 20'h00000; acc_type = 2'd2; acc_secure = 1'b1;
        #1;
        check("R10", "idle allow", 32'(acc_allow), 32'h0);

        // Table setup
        cfg_write(5'd1, 32'h03);
        cfg_write(5'd2, 32'h0D);
        cfg_write(5'd16, 32'h203);
        cfg_write(5'd11, 32'h01);
        cfg_write(5'd13, 32'h0B);
        cfg_read(5'd2, rd);  check("R2", "region word readback", rd, 32'h0D);
        cfg_read(5'd16, rd); check("R4", "window readback", rd, 32'h203);

        // Vector walk
        for (int i = 0; i < 16; i++) begin
            access(VECS[i].addr, VECS[i].kind, VECS[i].sec, al);
            checks++;
            if (al !== VECS[i].exp) begin
                failures++;
                $display("FAIL %s vector %0d actual=%0h expected=%0h",
                         VECS[i].req, i, al, VECS[i].exp);
            end
        end

        // R7: flags from the walk, clear, set, sticky, clear-vs-set
        cfg_read(5'd18, rd); check("R7", "flags after walk", rd, 32'h3);
        cfg_write(5'd18, 32'h3);
        cfg_read(5'd18, rd); check("R7", "flags cleared", rd, 32'h0);
        access(20'h00010, 2'd0, 1'b0, al);
        cfg_read(5'd18, rd); check("R7", "flash flag set", rd, 32'h1);
        repeat (3) @(negedge clk);
        cfg_read(5'd18, rd); check("R7", "flash flag sticky", rd, 32'h1);
        access(20'h83004, 2'd1, 1'b0, al);
        cfg_read(5'd18, rd); check("R7", "ram flag set", rd, 32'h3);
        cfg_write(5'd18, 32'h1);
        cfg_read(5'd18, rd); check("R7", "single clear", rd, 32'h2);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 20'h83004; acc_type = 2'd1; acc_secure = 1'b0;
        cfg_we = 1'b1; cfg_addr = 5'd18; cfg_wdata = 32'h2;
        @(negedge clk);
        acc_valid = 1'b0; cfg_we = 1'b0;
        cfg_read(5'd18, rd); check("R7", "violation beats clear", rd, 32'h2);

        // R8/R9: enables and interrupt
        check("R9", "irq masked", 32'(irq), 32'h0);
        cfg_write(5'd19, 32'h2);
        cfg_read(5'd19, rd); check("R8", "enable set", rd, 32'h2);
        cfg_read(5'd20, rd); check("R8", "enable via clear word", rd, 32'h2);
        check("R9", "irq ram", 32'(irq), 32'h1);
        cfg_write(5'd19, 32'h1);
        cfg_read(5'd19, rd); check("R8", "enable both", rd, 32'h3);
        cfg_write(5'd20, 32'h2);
        cfg_read(5'd19, rd); check("R8", "enable cleared", rd, 32'h1);
        check("R9", "irq flash enable no flag", 32'(irq), 32'h0);
        access(20'h00010, 2'd0, 1'b0, al);
        #1;
        check("R9", "irq after flash flag", 32'(irq), 32'h1);

        // R4: window size codes
        cfg_write(5'd16, 32'h209);
        access(20'h02FFF, 2'd2, 1'b0, al); check("R4", "code 9 disabled", 32'(al), 32'h0);
        cfg_write(5'd16, 32'h208);
        access(20'h02000, 2'd2, 1'b0, al); check("R4", "code 8 whole region", 32'(al), 32'h1);
        cfg_write(5'd16, 32'h200);
        access(20'h02FFF, 2'd2, 1'b0, al); check("R4", "code 0 disabled", 32'(al), 32'h0);
        cfg_write(5'd16, 32'h201);
        access(20'h02FE0, 2'd2, 1'b0, al); check("R4", "32B low edge in", 32'(al), 32'h1);
        access(20'h02FDF, 2'd2, 1'b0, al); check("R4", "32B below edge", 32'(al), 32'h0);
        cfg_write(5'd16, 32'h008);
        access(20'h02FFF, 2'd2, 1'b0, al); check("R4", "other region named", 32'(al), 32'h0);
        access(20'h00000, 2'd2, 1'b0, al); check("R4", "region 0 window", 32'(al), 32'h1);

        // R6: locks
        cfg_write(5'd1, 32'h13);
        cfg_read(5'd1, rd);  check("R6", "locked word", rd, 32'h13);
        cfg_write(5'd1, 32'h07);
        cfg_read(5'd1, rd);  check("R6", "write to locked ignored", rd, 32'h13);
        access(20'h01000, 2'd1, 1'b0, al); check("R6", "locked region still open", 32'(al), 32'h1);
        cfg_write(5'd16, 32'h10203);
        cfg_read(5'd16, rd); check("R6", "window locked", rd, 32'h10203);
        cfg_write(5'd16, 32'h0);
        cfg_read(5'd16, rd); check("R6", "window write ignored", rd, 32'h10203);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule